// File: doc/BRIEF.md
# Memory Row Boundary Decoder

This block works out which of four memory rows (chip selects) a physical address belongs to. Software programs one 8-bit upper-boundary value per row. Each value, taken in 16 MB units, gives the exclusive top of that row. The rows are laid end to end: row 0 starts at address zero, and every later row starts where the row before it stops.

A row whose top equals the previous row's top holds no memory and is skipped. A row whose value is below the previous one is handled the same way, as an empty row. An address at or above the top of the highest populated row is reported as a miss and drives no chip select.

Each lookup is presented with a valid strobe. The result comes back exactly one clock later as a one-hot chip select, a binary row index and a miss flag, with a matching valid output.

Top module: `rbd_top`

## Requirements
- R1: Four 8-bit boundary registers are written with `cfg_we`; `cfg_sel` picks the row, where value i writes row i (0 to 3). A written value changes the decode of every lookup presented after the write.
- R2: The exclusive upper limit of row i is its boundary value times 2^24. Only address bits [30:24] take part in the comparison, and a value of 0x80 or more covers the whole 31-bit address span.
- R3: Row 0 covers addresses from 0 up to its limit. Row i (i>0) covers addresses from the limit of row i-1 up to its own limit.
- R4: A row whose limit equals the limit of the row before it is empty and is never selected; addresses pass on to the next populated row. For row 0, the limit before it is 0.
- R5: A boundary smaller than an earlier row's limit is treated as equal to the largest earlier limit, so that row is empty.
- R6: An address at or above the highest effective limit sets `rsp_miss` and returns `rsp_cs` = 0 and `rsp_row` = 0.
- R7: On a hit, `rsp_cs` has exactly bit i set, where i is the selected row, and `rsp_row` is i in binary.
- R8: `rsp_valid` follows `req_valid` one cycle later. A cycle with no request returns `rsp_cs` = 0, `rsp_row` = 0 and `rsp_miss` = 0. Back-to-back requests each return their own result.
- R9: Synchronous reset clears all boundaries to 0 and clears `rsp_valid`. After reset, every address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Boundary register write strobe |
| cfg_sel | input | 2 | Row whose boundary is written |
| cfg_wdata | input | 8 | Boundary value, in 16 MB units |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 31 | Physical address to decode |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_cs | output | 4 | One-hot chip select |
| rsp_row | output | 2 | Selected row index |
| rsp_miss | output | 1 | Address lies above the last populated row |

## Verification
The assertions check properties that hold on every cycle. They check the one-cycle valid pipeline, that the chip select is one-hot and agrees with the row index, that a miss never drives a chip select, that idle cycles return a zero result, and that a row whose effective limit equals its predecessor's is never selected. Only the bench's scenarios can show that the right row is chosen for a given address. The bench covers addresses just below and exactly at each limit, skipping over an empty middle row, clamping a decreasing boundary, the full-span boundary value, and the reset state in which everything misses.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    localparam int NUM_ROWS    = 4;
    localparam int ROW_W       = $clog2(NUM_ROWS);
    localparam int BND_W       = 8;
    localparam int ADDR_W      = 31;
    localparam int LIMIT_SHIFT = 24;
    localparam int TAG_W       = ADDR_W - LIMIT_SHIFT;
    localparam int CMP_W       = (TAG_W > BND_W) ? TAG_W : BND_W;

    typedef logic [BND_W-1:0]  bnd_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [NUM_ROWS-1:0] cs_t;

    typedef struct packed {
        cs_t  cs;
        row_t row;
        logic miss;
    } decode_t;

    // Larger of two boundaries: keeps the limit chain non-decreasing.
    function automatic bnd_t bnd_max(bnd_t a, bnd_t b);
        return (a > b) ? a : b;
    endfunction

    // The limit has zero low bits, so a compare of the upper bits is exact.
    function automatic logic tag_below(tag_t tag, bnd_t lim);
        logic [CMP_W-1:0] t;
        logic [CMP_W-1:0] l;
        t = CMP_W'(tag);
        l = CMP_W'(lim);
        return t < l;
    endfunction

endpackage

// File: rtl/rbd_bound_regs.sv
module rbd_bound_regs
    import rbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  row_t       cfg_sel,
    input  bnd_t       cfg_wdata,
    output bnd_t       eff_lim [NUM_ROWS]
);

    bnd_t raw_bnd [NUM_ROWS];

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_bnd[i] <= '0;
            end else if (cfg_we && (cfg_sel == row_t'(i))) begin
                raw_bnd[i] <= cfg_wdata;
            end
        end

        if (i == 0) begin : g_first
            assign eff_lim[i] = raw_bnd[i];
        end else begin : g_chain
            // R5: a decreasing boundary collapses onto the previous limit
            assign eff_lim[i] = bnd_max(eff_lim[i-1], raw_bnd[i]);
        end
    end

    // R9: after a reset cycle every limit is zero, so all rows are empty
    assert_reset_empty_R9: assert property (@(posedge clk)
        rst |=> (eff_lim[NUM_ROWS-1] == '0));

endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match
    import rbd_pkg::*;
(
    input  tag_t    tag,
    input  bnd_t    eff_lim [NUM_ROWS],
    output decode_t result
);

    logic [NUM_ROWS-1:0] below;
    cs_t                 cs;

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
        assign below[i] = tag_below(tag, eff_lim[i]);
        if (i == 0) begin : g_first
            assign cs[i] = below[i];
        end else begin : g_rest
            // R3/R4: row i is hit only above the previous limit
            assign cs[i] = below[i] & ~below[i-1];
        end
    end

    always_comb begin
        result.cs   = cs;
        result.miss = ~below[NUM_ROWS-1];
        result.row  = '0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (cs[i]) begin
                result.row = row_t'(i);
            end
        end
    end

endmodule

// File: rtl/rbd_top.sv
module rbd_top
    import rbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ROW_W-1:0]  cfg_sel,
    input  logic [BND_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [NUM_ROWS-1:0] rsp_cs,
    output logic [ROW_W-1:0]  rsp_row,
    output logic              rsp_miss
);

    bnd_t    eff_lim [NUM_ROWS];
    decode_t dec_now;
    decode_t dec_q;

    rbd_bound_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .eff_lim   (eff_lim)
    );

    rbd_row_match u_match (
        .tag     (req_addr[ADDR_W-1:LIMIT_SHIFT]),
        .eff_lim (eff_lim),
        .result  (dec_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            dec_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            dec_q     <= req_valid ? dec_now : '0;
        end
    end

    assign rsp_cs   = dec_q.cs;
    assign rsp_row  = dec_q.row;
    assign rsp_miss = dec_q.miss;

    // R8: one-cycle latency, idle cycles carry a zero result
    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_cs == '0 && !rsp_miss && rsp_row == '0));

    // R7: one-hot select that agrees with the row index
    assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_cs));
    assert_cs_row_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_miss) |-> (rsp_cs == (cs_t'(1) << rsp_row)));

    // R6: a miss drives no chip select; a valid hit always drives one
    assert_miss_no_cs_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_cs == '0 && rsp_row == '0));
    assert_hit_has_cs_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_miss) |-> $countones(rsp_cs) == 1);

    // R4: an empty row is never selected
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_chk
        if (i == 0) begin : g_first
            assert_empty_row_R4: assert property (@(posedge clk) disable iff (rst)
                (rsp_valid && rsp_cs[i] && !$past(rst)) |-> ($past(eff_lim[i]) != '0));
        end else begin : g_rest
            assert_empty_row_R4: assert property (@(posedge clk) disable iff (rst)
                (rsp_valid && rsp_cs[i] && !$past(rst)) |->
                    ($past(eff_lim[i]) != $past(eff_lim[i-1])));
        end
    end

endmodule

// File: tb/tb_rbd_top.sv
module tb_rbd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [30:0] req_addr = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_cs;
    logic [1:0]  rsp_row;
    logic        rsp_miss;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rbd_top dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_cs    (rsp_cs),
        .rsp_row   (rsp_row),
        .rsp_miss  (rsp_miss)
    );

    // {addr[30:0], cs[3:0], row[1:0], miss} with limits 0x02,0x06,0x06,0x16
    localparam logic [37:0] VEC [10] = '{
        {31'h0000_0000, 4'b0001, 2'd0, 1'b0},   // R3 row 0 base
        {31'h01FF_FFFF, 4'b0001, 2'd0, 1'b0},   // R2 just below limit 0
        {31'h0200_0000, 4'b0010, 2'd1, 1'b0},   // R3 row 1 base
        {31'h05FF_FFFF, 4'b0010, 2'd1, 1'b0},   // R2 just below limit 1
        {31'h0600_0000, 4'b1000, 2'd3, 1'b0},   // R4 skips empty row 2
        {31'h0A12_3456, 4'b1000, 2'd3, 1'b0},   // R7 interior of row 3
        {31'h15FF_FFFF, 4'b1000, 2'd3, 1'b0},   // R2 just below limit 3
        {31'h1600_0000, 4'b0000, 2'd0, 1'b1},   // R6 exactly at top
        {31'h7FFF_FFFF, 4'b0000, 2'd0, 1'b1},   // R6 top of span
        {31'h0100_0000, 4'b0001, 2'd0, 1'b0}    // R7 row 0 again
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_rsp(input string req, input logic [3:0] ecs,
                             input logic [1:0] erow, input logic emiss);
        check(rsp_valid === 1'b1, req, "valid", {7'd0, rsp_valid}, 8'd1);
        check(rsp_cs === ecs, req, "cs", {4'd0, rsp_cs}, {4'd0, ecs});
        check(rsp_row === erow, req, "row", {6'd0, rsp_row}, {6'd0, erow});
        check(rsp_miss === emiss, req, "miss", {7'd0, rsp_miss}, {7'd0, emiss});
    endtask

    task automatic write_bnd(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [30:0] addr, input string req,
                          input logic [3:0] ecs, input logic [1:0] erow,
                          input logic emiss);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req, ecs, erow, emiss);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(rsp_valid === 1'b0, "R9", "valid after reset", {7'd0, rsp_valid}, 8'd0);
        lookup(31'h0000_0000, "R9", 4'b0000, 2'd0, 1'b1);
        lookup(31'h7FFF_FFFF, "R9", 4'b0000, 2'd0, 1'b1);

        // R1: program boundaries through the write port
        write_bnd(2'd0, 8'h02);
        write_bnd(2'd1, 8'h06);
        write_bnd(2'd2, 8'h06);
        write_bnd(2'd3, 8'h16);

        for (int i = 0; i < 10; i++) begin
            lookup(VEC[i][37:7], "R1/R2/R3/R4/R6/R7 vector",
                   VEC[i][6:3], VEC[i][2:1], VEC[i][0]);
        end

        // R8: idle cycle gives a zero result
        @(negedge clk);
        check(rsp_valid === 1'b0, "R8", "idle valid", {7'd0, rsp_valid}, 8'd0);
        check(rsp_cs === 4'b0, "R8", "idle cs", {4'd0, rsp_cs}, 8'd0);
        check(rsp_miss === 1'b0, "R8", "idle miss", {7'd0, rsp_miss}, 8'd0);

        // R8: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_addr = 31'h0300_0000;
        @(negedge clk);
        check_rsp("R8 b2b first", 4'b0010, 2'd1, 1'b0);
        req_addr = 31'h1700_0000;
        @(negedge clk);
        check_rsp("R8 b2b second", 4'b0000, 2'd0, 1'b1);
        req_addr = 31'h0000_1000;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R8 b2b third", 4'b0001, 2'd0, 1'b0);

        // R5: decreasing boundary treated as empty; R4 empty last row
        write_bnd(2'd0, 8'h04);
        write_bnd(2'd1, 8'h02);
        write_bnd(2'd2, 8'h08);
        write_bnd(2'd3, 8'h08);
        lookup(31'h0300_0000, "R5", 4'b0001, 2'd0, 1'b0);
        lookup(31'h0100_0000, "R5", 4'b0001, 2'd0, 1'b0);
        lookup(31'h0500_0000, "R5", 4'b0100, 2'd2, 1'b0);
        lookup(31'h0800_0000, "R4", 4'b0000, 2'd0, 1'b1);

        // R4: empty row 0 passes addresses to row 1
        write_bnd(2'd0, 8'h00);
        lookup(31'h0000_0000, "R4", 4'b0010, 2'd1, 1'b0);

        // R2: full-span boundary value covers every address
        write_bnd(2'd0, 8'hFF);
        lookup(31'h7FFF_FFFF, "R2", 4'b0001, 2'd0, 1'b0);
        write_bnd(2'd0, 8'h80);
        lookup(31'h7FFF_FFFF, "R2", 4'b0001, 2'd0, 1'b0);

        // R9: reset again returns everything to miss
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(rsp_valid === 1'b0, "R9", "valid after second reset", {7'd0, rsp_valid}, 8'd0);
        lookup(31'h0000_0000, "R9", 4'b0000, 2'd0, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule